// File: doc/BRIEF.md
# Multi-dimensional strided address generator

This block produces a stream of byte addresses for vector-sized loads from a flat buffer. The access pattern has up to three nested dimensions. Each dimension is described by a size and a step, and both are counted in whole vectors. A consumer takes one address per handshake. Each accepted address moves a three-digit odometer forward. The innermost digit turns fastest, the middle digit turns when the inner one wraps, and the outermost digit counts without limit.

The pattern is configured by software-independent inputs: a base address, a vector-width code and the sizes and steps. Those values are captured only when `restart` is pulsed. A restart also clears every index. A step of zero repeats the inner pattern at the same addresses. An outer step smaller than an inner step gives addresses that move backward and forward. An unused dimension is configured with size 1 and step 0.

Top module: `strided_addr_gen`

## Requirements
- R1: After synchronous reset, and until the first restart, `addr_valid` is 0 and `addr_out` is 0.
- R2: The cycle after `restart` is high, `addr_valid` is 1 and `addr_out` equals the `cfg_base` sampled with the restart, with all indices at zero. A restart overrides an accept in the same cycle.
- R3: The vector width in bytes is W = 4 << `cfg_wsel` for codes 0 to 5, and codes 6 and 7 act as code 5. Every address equals base + W*i2*step2 + W*i1*step1 + W*i0*step0.
- R4: Each accept (`addr_valid` and `addr_ready` both high, no restart) advances i0. When i0 is size0-1, i0 returns to 0 and i1 advances.
- R5: When i1 is size1-1 and i0 wraps, i1 returns to 0 and i2 increments without bound.
- R6: A dimension with step 0 repeats the addresses of the dimensions inside it, once for each value of its index.
- R7: An outer step smaller than an inner one yields backward jumps in the address stream, exactly as given by the R3 formula, with no reordering.
- R8: While `addr_valid` is 1 and `addr_ready` is 0, `addr_out` holds its value and `addr_valid` stays 1.
- R9: Configuration inputs changed while `restart` is low have no effect until the next restart.
- R10: All address arithmetic is 32-bit unsigned and wraps modulo 2^32.
- R11: A size of 0 acts as a size of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Captures the configuration and clears all indices |
| cfg_base | input | 32 | Base byte address |
| cfg_wsel | input | 3 | Vector width code, W = 4 << code |
| cfg_size0 | input | 16 | Inner dimension size in vectors |
| cfg_size1 | input | 16 | Middle dimension size in vectors |
| cfg_step0 | input | 32 | Inner step in vectors |
| cfg_step1 | input | 32 | Middle step in vectors |
| cfg_step2 | input | 32 | Outer step in vectors |
| addr_valid | output | 1 | An address is presented |
| addr_ready | input | 1 | The consumer accepts the address |
| addr_out | output | 32 | Byte address |

## Verification
A restart and an accepted handshake can fall in the same cycle, and the restart must win. The bench provokes this by raising `restart` while `addr_ready` is high and `addr_valid` is high partway through a pattern, both in a directed case and at random points. It then judges the next address against a reference odometer that was reset to zero and not advanced. The same reference also covers stalls, which land on random cycles and must leave the held address unchanged.

// File: rtl/strided_pkg.sv
package strided_pkg;
  localparam int MAX_WSEL = 5;
  localparam int W_LOG2_MIN = 2;

  // Byte shift that turns a step in vectors into a step in bytes.
  function automatic int unsigned vec_shift(input logic [2:0] wsel);
    int unsigned s;
    s = (int'(wsel) > MAX_WSEL) ? MAX_WSEL : int'(wsel);
    return s + W_LOG2_MIN;
  endfunction
endpackage

// File: rtl/strided_cfg.sv
module strided_cfg
  import strided_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16,
  parameter int WSEL_W = 3,
  parameter int NDIM   = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         restart,
  input  logic [ADDR_W-1:0]            cfg_base,
  input  logic [WSEL_W-1:0]            cfg_wsel,
  input  logic [NDIM-2:0][IDX_W-1:0]   cfg_size,
  input  logic [NDIM-1:0][ADDR_W-1:0]  cfg_step,
  output logic [ADDR_W-1:0]            base_q,
  output logic [NDIM-2:0][IDX_W-1:0]   size_q,
  output logic [NDIM-1:0][ADDR_W-1:0]  delta_q
);
  logic [2:0] wsel3;
  assign wsel3 = 3'(cfg_wsel);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      size_q <= '0;
    end else if (restart) begin
      base_q <= cfg_base;
      size_q <= cfg_size;
    end
  end

  for (genvar d = 0; d < NDIM; d++) begin : g_delta
    always_ff @(posedge clk) begin
      if (rst) delta_q[d] <= '0;
      else if (restart) delta_q[d] <= cfg_step[d] << vec_shift(wsel3);
    end
  end

  // Captured configuration only moves on a restart.
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !restart |=> ($stable(base_q) && $stable(size_q) && $stable(delta_q)));
  assert_cfg_capture_R2: assert property (@(posedge clk) disable iff (rst)
    restart |=> (base_q == $past(cfg_base)));
endmodule

// File: rtl/strided_dim.sv
module strided_dim #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              adv,
  input  logic [IDX_W-1:0]  size,
  input  logic [ADDR_W-1:0] delta,
  output logic [ADDR_W-1:0] off_nxt,
  output logic              wrap
);
  logic [IDX_W-1:0]  idx_q, idx_nxt;
  logic [ADDR_W-1:0] off_q;
  logic              last;

  // Size 0 satisfies the compare at once, so it behaves as size 1.
  assign last = ({1'b0, idx_q} + {{IDX_W{1'b0}}, 1'b1}) >= {1'b0, size};
  assign wrap = adv && !clear && last;

  always_comb begin
    idx_nxt = idx_q;
    off_nxt = off_q;
    if (clear) begin
      idx_nxt = '0;
      off_nxt = '0;
    end else if (adv) begin
      if (last) begin
        idx_nxt = '0;
        off_nxt = '0;
      end else begin
        idx_nxt = idx_q + 1'b1;
        off_nxt = off_q + delta;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      off_q <= '0;
    end else begin
      idx_q <= idx_nxt;
      off_q <= off_nxt;
    end
  end

  assert_idx_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (idx_q == '0) || (idx_q < size));
  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (idx_q == '0 && off_q == '0));
  assert_adv_step_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && !clear && !last) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/strided_addr_gen.sv
module strided_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16,
  parameter int WSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [WSEL_W-1:0] cfg_wsel,
  input  logic [IDX_W-1:0]  cfg_size0,
  input  logic [IDX_W-1:0]  cfg_size1,
  input  logic [ADDR_W-1:0] cfg_step0,
  input  logic [ADDR_W-1:0] cfg_step1,
  input  logic [ADDR_W-1:0] cfg_step2,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int NDIM = 3;
  localparam int NBND = NDIM - 1;

  logic [ADDR_W-1:0]           base_q;
  logic [NBND-1:0][IDX_W-1:0]  size_q;
  logic [NDIM-1:0][ADDR_W-1:0] delta_q;
  logic [NBND-1:0][ADDR_W-1:0] off_nxt;
  logic [NBND-1:0]             wrap;
  logic [NBND:0]               adv;
  logic [ADDR_W-1:0]           off2_q, off2_nxt, base_sel, sum_nxt;
  logic                        fire;

  strided_cfg #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W), .NDIM(NDIM)) u_cfg (
    .clk(clk), .rst(rst), .restart(restart),
    .cfg_base(cfg_base), .cfg_wsel(cfg_wsel),
    .cfg_size({cfg_size1, cfg_size0}),
    .cfg_step({cfg_step2, cfg_step1, cfg_step0}),
    .base_q(base_q), .size_q(size_q), .delta_q(delta_q)
  );

  assign fire   = addr_valid && addr_ready && !restart;
  assign adv[0] = fire;

  for (genvar d = 0; d < NBND; d++) begin : g_dim
    strided_dim #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dim (
      .clk(clk), .rst(rst), .clear(restart), .adv(adv[d]),
      .size(size_q[d]), .delta(delta_q[d]),
      .off_nxt(off_nxt[d]), .wrap(wrap[d])
    );
    assign adv[d+1] = wrap[d];
  end

  // Outermost dimension: unbounded accumulator.
  always_comb begin
    off2_nxt = off2_q;
    if (restart)        off2_nxt = '0;
    else if (adv[NBND]) off2_nxt = off2_q + delta_q[NBND];
  end

  assign base_sel = restart ? cfg_base : base_q;
  assign sum_nxt  = base_sel + off2_nxt + off_nxt[1] + off_nxt[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      off2_q     <= '0;
      addr_valid <= 1'b0;
      addr_out   <= '0;
    end else begin
      off2_q <= off2_nxt;
      if (restart || fire) begin
        addr_valid <= 1'b1;
        addr_out   <= sum_nxt;
      end
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !addr_ready && !restart) |=> (addr_valid && $stable(addr_out)));
  assert_restart_base_R2: assert property (@(posedge clk) disable iff (rst)
    restart |=> (addr_valid && addr_out == $past(cfg_base)));
  assert_valid_origin_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_valid) |-> $past(restart));
endmodule

// File: tb/test_strided_addr_gen.sv
module test_strided_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        restart = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [2:0]  cfg_wsel = '0;
  logic [15:0] cfg_size0 = '0, cfg_size1 = '0;
  logic [31:0] cfg_step0 = '0, cfg_step1 = '0, cfg_step2 = '0;
  logic        addr_valid, addr_ready = 1'b0;
  logic [31:0] addr_out;

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference state
  logic [31:0] m_base, m_s0, m_s1, m_s2, m_w;
  int unsigned m_sz0, m_sz1, m_i0, m_i1, m_i2;
  bit m_valid = 0;

  always #5 clk = ~clk;

  strided_addr_gen i_strided_addr_gen (
    .clk(clk), .rst(rst), .restart(restart), .cfg_base(cfg_base), .cfg_wsel(cfg_wsel),
    .cfg_size0(cfg_size0), .cfg_size1(cfg_size1), .cfg_step0(cfg_step0),
    .cfg_step1(cfg_step1), .cfg_step2(cfg_step2), .addr_valid(addr_valid),
    .addr_ready(addr_ready), .addr_out(addr_out)
  );

  function automatic logic [31:0] model_addr();
    return m_base + m_w * m_i2 * m_s2 + m_w * m_i1 * m_s1 + m_w * m_i0 * m_s0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Compare outputs against the model, away from the clock edge.
  task automatic compare(input string tag);
    check({tag, " valid"}, {31'b0, addr_valid}, {31'b0, m_valid});
    if (m_valid) check({tag, " addr"}, addr_out, model_addr());
  endtask

  // Apply one cycle of inputs, then advance the model.
  task automatic cycle(input bit rs, input bit rdy);
    restart = rs;
    addr_ready = rdy;
    @(posedge clk);
    #1;
    if (rs) begin
      m_base = cfg_base;
      m_w = 32'd4 << ((cfg_wsel > 3'd5) ? 3'd5 : cfg_wsel);
      m_sz0 = (cfg_size0 == 0) ? 1 : cfg_size0;
      m_sz1 = (cfg_size1 == 0) ? 1 : cfg_size1;
      m_s0 = cfg_step0; m_s1 = cfg_step1; m_s2 = cfg_step2;
      m_i0 = 0; m_i1 = 0; m_i2 = 0; m_valid = 1;
    end else if (m_valid && rdy) begin
      m_i0++;
      if (m_i0 >= m_sz0) begin
        m_i0 = 0; m_i1++;
        if (m_i1 >= m_sz1) begin m_i1 = 0; m_i2++; end
      end
    end
    restart = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [31:0] b, input logic [2:0] ws,
                         input logic [15:0] z0, input logic [15:0] z1,
                         input logic [31:0] s0, input logic [31:0] s1, input logic [31:0] s2);
    cfg_base = b; cfg_wsel = ws; cfg_size0 = z0; cfg_size1 = z1;
    cfg_step0 = s0; cfg_step1 = s1; cfg_step2 = s2;
  endtask

  task automatic expect_seq(input string tag, input int n, input logic [31:0] first, input logic [31:0] inc);
    for (int k = 0; k < n; k++) begin
      check(tag, addr_out, first + inc * k);
      cycle(0, 1);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    check("R1 valid", {31'b0, addr_valid}, 32'd0);
    check("R1 addr", addr_out, 32'd0);
    cycle(0, 1);
    check("R1 no restart", {31'b0, addr_valid}, 32'd0);

    // R3 R4: single dimension, W=32, step 2 -> stride 64
    set_cfg(32'd0, 3'd3, 16'd4, 16'd1, 32'd2, 32'd0, 32'd8);
    cycle(1, 0);
    check("R2 first addr", addr_out, 32'd0);
    expect_seq("R3 single dim", 8, 32'd0, 32'd64);

    // R4 R5: outer (2,8) inner (4,2), W=32
    set_cfg(32'd0, 3'd3, 16'd4, 16'd2, 32'd2, 32'd8, 32'd16);
    cycle(1, 1);
    expect_seq("R5 two level", 8, 32'd0, 32'd64);
    check("R5 outer carry", addr_out, 32'd512);

    // R6: zero step repeats the inner pattern
    set_cfg(32'h100, 3'd0, 16'd3, 16'd2, 32'd1, 32'd0, 32'd0);
    cycle(1, 0);
    for (int r = 0; r < 4; r++) expect_seq("R6 repeat", 3, 32'h100, 32'd4);

    // R7: inner step 4, outer step 1, W=4 -> back and forth
    set_cfg(32'h0, 3'd0, 16'd3, 16'd3, 32'd4, 32'd1, 32'd0);
    cycle(1, 0);
    expect_seq("R7 row0", 3, 32'd0, 32'd16);
    expect_seq("R7 row1", 3, 32'd4, 32'd16);

    // R10: wrap modulo 2^32; R11: size 0 acts as 1; wsel 7 acts as 5
    set_cfg(32'hFFFF_FFC0, 3'd7, 16'd0, 16'd0, 32'd5, 32'd9, 32'd1);
    cycle(1, 0);
    expect_seq("R10 R11 wrap", 4, 32'hFFFF_FFC0, 32'd128);

    // R9: config changes without restart are ignored
    set_cfg(32'h1000, 3'd1, 16'd2, 16'd2, 32'd1, 32'd3, 32'd7);
    cycle(1, 0);
    set_cfg(32'hDEAD_0000, 3'd4, 16'd9, 16'd9, 32'd99, 32'd99, 32'd99);
    check("R9 base kept", addr_out, 32'h1000);
    cycle(0, 1);
    check("R9 step kept", addr_out, 32'h1008);
    cycle(0, 1);
    check("R9 size kept", addr_out, 32'h1000 + 32'd24);

    // R2: restart together with an accept; R8: stall holds
    set_cfg(32'h2000, 3'd2, 16'd3, 16'd2, 32'd1, 32'd4, 32'd2);
    cycle(1, 1);
    cycle(0, 1);
    cycle(0, 0);
    check("R8 hold", addr_out, 32'h2010);
    cycle(0, 0);
    check("R8 hold again", addr_out, 32'h2010);
    cycle(1, 1);
    check("R2 restart wins", addr_out, 32'h2000);

    // Random patterns with random stalls and restarts
    for (int t = 0; t < 40; t++) begin
      set_cfg($urandom, 3'($urandom_range(0, 7)), 16'($urandom_range(0, 5)),
              16'($urandom_range(0, 5)), $urandom_range(0, 6), $urandom_range(0, 6),
              ($urandom_range(0, 3) == 0) ? $urandom : $urandom_range(0, 6));
      cycle(1, 1'($urandom_range(0, 1)));
      for (int c = 0; c < 150; c++) begin
        compare("R3 R8 random");
        if ($urandom_range(0, 3) == 0) set_cfg($urandom, 3'($urandom), 16'($urandom), 16'($urandom),
                                               $urandom, $urandom, $urandom);
        cycle($urandom_range(0, 60) == 0, $urandom_range(0, 3) != 0);
      end
    end
    finish_run();
  end
endmodule